// File: doc/BRIEF.md
# Processor operation control register

This block holds one 64-bit processor configuration word that software reads and writes as a whole. Most of its defined bits are plain control bits that load from the write data. Four bits follow other update rules. Two bits can be loaded only once per reset. Two status flags are set by hardware and cleared only by software. The parity-checking bit and the cache-enable bit also clear themselves when the block reacts to a parity error.

When a cache parity error is reported while parity checking is on, the block does four things at one clock edge:
- it turns cache use off;
- it turns parity checking off;
- it records the error;
- it raises a one-cycle cache flush request and a one-cycle non-maskable interrupt request.

A parity error that arrives while checking is off only records the error. The block also decodes a few bits into effective controls:
- flush snooping takes effect only while the snoop input is disabled;
- the low-power halt and PLA power-down outputs follow the halt indication.

Top module: `proc_opctl_reg`

## Requirements
- R1: After reset, rd_data_o is all zero and flush_req_o and nmi_req_o are low.
- R2: On a write, bits 1, 2, 3, 4, 5, 6, 7, 9, 12, 13, 15, 16, 17 and 18 take the write data at the clock edge. The new value appears on rd_data_o in the following cycle.
- R3: Bits 63..19 and bit 8 always read 0, whatever data is written.
- R4: Bit 14 (error-pin redirect) and bit 10 (cacheable-limit source) load the write data only on the first write after reset. Any write arms the lock, and only reset clears it.
- R5: A parity error sampled while bit 1 is 1 has these effects in the next cycle: bit 1 = 0, bit 7 = 0, bit 0 = 1, and flush_req_o and nmi_req_o are high for exactly one cycle.
- R6: A parity error sampled while bit 1 is 0 sets bit 0. No other bit changes, and neither request pulse is raised.
- R7: Bit 0 stays 1 until a write with data bit 0 = 0 clears it. A write with data bit 0 = 1 never sets it.
- R8: Bit 11 is set by reload_evt_i and is cleared by a write with data bit 11 = 0. A write with data bit 11 = 1 never sets it. A reload event in the same cycle as a clearing write leaves the bit set.
- R9: When a write and a parity error (with bit 1 = 1) fall in the same cycle, the parity-error effects on bits 0, 1 and 7 win. All other writable bits take the write data.
- R10: flush_snoop_o is 1 only when bit 4 is 1 and bit 3 is 0.
- R11: halt_clk_stop_o equals halt_i AND bit 13. pla_pwrdn_o equals halt_clk_stop_o AND bit 18.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Software write strobe |
| wr_data_i | input | 64 | Software write data |
| par_err_i | input | 1 | Cache parity error indication |
| reload_evt_i | input | 1 | Internal cache reload happened |
| halt_i | input | 1 | Processor is in the halt state |
| rd_data_o | output | 64 | Current register value |
| flush_req_o | output | 1 | One-cycle cache flush request |
| nmi_req_o | output | 1 | One-cycle non-maskable interrupt request |
| par_flag_o | output | 1 | Parity error recorded (bit 0) |
| par_chk_en_o | output | 1 | Parity checking enabled (bit 1) |
| a20_mask_o | output | 1 | Address line 20 masking (bit 2) |
| snoop_en_o | output | 1 | Snoop input enabled (bit 3) |
| flush_snoop_o | output | 1 | Effective flush snooping |
| pwr_int_en_o | output | 1 | Power interrupt enabled (bit 5) |
| rgn_nocache_o | output | 1 | Fixed 4K region made uncacheable (bit 6) |
| cache_en_o | output | 1 | Internal cache enabled (bit 7) |
| lock_nocache_o | output | 1 | Locked cycles not cached (bit 9) |
| limit_src_o | output | 1 | Cacheable-limit source select (bit 10) |
| reload_seen_o | output | 1 | Cache reload status (bit 11) |
| out_wait_rdy_o | output | 1 | Wait for ready after output (bit 12) |
| halt_clk_stop_o | output | 1 | Stop the internal clock during halt |
| err_redirect_o | output | 1 | Error pin redirected to strobe output (bit 14) |
| fp_cacheable_o | output | 1 | Floating-point operand reads cacheable (bit 15) |
| par_odd_o | output | 1 | Odd cache parity test mode (bit 16) |
| force_ext_rd_o | output | 1 | Force reads to external memory (bit 17) |
| pla_pwrdn_o | output | 1 | Extra power-down during low-power halt |

## Verification
The assertions assume that par_err_i, reload_evt_i, wr_en_i and halt_i are sampled only at the rising clock edge. They also assume these inputs hold known values whenever reset is released. The stimulus meets this by changing every input only on the falling edge and by driving every input to a defined level before reset is released. The checks on the request pulses and the sticky flags also assume that the parity-error effect is judged against the bit 1 value held in the register, not against the bit 1 value of a write in the same cycle. The bench vectors that combine a write with a parity error rely on the same assumption.

// File: rtl/opctl_pkg.sv
package opctl_pkg;
   // bit positions the surrounding logic decodes
   localparam int BIT_PFLAG  = 0;
   localparam int BIT_PCHK   = 1;
   localparam int BIT_A20    = 2;
   localparam int BIT_SNOOP  = 3;
   localparam int BIT_FSNOOP = 4;
   localparam int BIT_PWRINT = 5;
   localparam int BIT_RGNNC  = 6;
   localparam int BIT_CEN    = 7;
   localparam int BIT_HOLE   = 8;
   localparam int BIT_LOCKNC = 9;
   localparam int BIT_LIMSRC = 10;
   localparam int BIT_RELOAD = 11;
   localparam int BIT_OWAIT  = 12;
   localparam int BIT_LPHALT = 13;
   localparam int BIT_ERRRDR = 14;
   localparam int BIT_FPC    = 15;
   localparam int BIT_PODD   = 16;
   localparam int BIT_FEXT   = 17;
   localparam int BIT_PLA    = 18;
   localparam int USED_BITS  = 19;

   typedef enum logic [1:0] {
      KIND_RSVD,
      KIND_PLAIN,
      KIND_SPECIAL
   } bit_kind_e;

   function automatic bit_kind_e kind_of(int idx);
      if (idx >= USED_BITS || idx == BIT_HOLE) return KIND_RSVD;
      if (idx == BIT_PFLAG || idx == BIT_RELOAD ||
          idx == BIT_ERRRDR || idx == BIT_LIMSRC) return KIND_SPECIAL;
      return KIND_PLAIN;
   endfunction

   function automatic bit clears_on_trip(int idx);
      return (idx == BIT_PCHK) || (idx == BIT_CEN);
   endfunction
endpackage

// File: rtl/opctl_sticky_bit.sv
module opctl_sticky_bit (
   input  logic clk,
   input  logic rst_n,
   input  logic hw_set,
   input  logic sw_clr,
   output logic q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      q <= 1'b0;
      else if (hw_set) q <= 1'b1;
      else if (sw_clr) q <= 1'b0;
   end

   // R7 R8
   sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (q && !sw_clr) |=> q);
endmodule

// File: rtl/opctl_once_field.sv
module opctl_once_field #(
   parameter int N = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         wr_en,
   input  logic [N-1:0] d,
   output logic [N-1:0] q
);
   generate
      if (N < 1) begin : g_bad_n
         $error("opctl_once_field: N must be at least 1");
      end
   endgenerate

   logic armed_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     armed_q <= 1'b0;
      else if (wr_en) armed_q <= 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                q <= '0;
      else if (wr_en && !armed_q) q <= d;
   end

   // R4
   once_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      armed_q |=> $stable(q));
endmodule

// File: rtl/opctl_par_guard.sv
module opctl_par_guard #(
   parameter bit NMI_ON_TRIP = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic par_err,
   input  logic chk_en,
   output logic trip,
   output logic flush_req,
   output logic nmi_req
);
   assign trip = par_err & chk_en;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flush_req <= 1'b0;
      else        flush_req <= trip;
   end

   generate
      if (NMI_ON_TRIP) begin : g_nmi
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) nmi_req <= 1'b0;
            else        nmi_req <= trip;
         end
      end else begin : g_no_nmi
         assign nmi_req = 1'b0;
      end
   endgenerate

   // R5
   pulse_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      flush_req |=> !flush_req);
endmodule

// File: rtl/proc_opctl_reg.sv
module proc_opctl_reg
   import opctl_pkg::*;
#(
   parameter int REG_W       = 64,
   parameter bit NMI_ON_TRIP = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en_i,
   input  logic [REG_W-1:0] wr_data_i,
   input  logic             par_err_i,
   input  logic             reload_evt_i,
   input  logic             halt_i,
   output logic [REG_W-1:0] rd_data_o,
   output logic             flush_req_o,
   output logic             nmi_req_o,
   output logic             par_flag_o,
   output logic             par_chk_en_o,
   output logic             a20_mask_o,
   output logic             snoop_en_o,
   output logic             flush_snoop_o,
   output logic             pwr_int_en_o,
   output logic             rgn_nocache_o,
   output logic             cache_en_o,
   output logic             lock_nocache_o,
   output logic             limit_src_o,
   output logic             reload_seen_o,
   output logic             out_wait_rdy_o,
   output logic             halt_clk_stop_o,
   output logic             err_redirect_o,
   output logic             fp_cacheable_o,
   output logic             par_odd_o,
   output logic             force_ext_rd_o,
   output logic             pla_pwrdn_o
);
   localparam int ONCE_N = 2;

   generate
      if (REG_W < USED_BITS) begin : g_bad_w
         $error("proc_opctl_reg: REG_W too small for the defined fields");
      end
   endgenerate

   logic              trip;
   logic              flag_q;
   logic              reload_q;
   logic [ONCE_N-1:0] once_q;
   logic [REG_W-1:0]  reg_q;

   opctl_par_guard #(.NMI_ON_TRIP(NMI_ON_TRIP)) u_guard (
      .clk       (clk),
      .rst_n     (rst_n),
      .par_err   (par_err_i),
      .chk_en    (reg_q[BIT_PCHK]),
      .trip      (trip),
      .flush_req (flush_req_o),
      .nmi_req   (nmi_req_o)
   );

   opctl_sticky_bit u_pflag (
      .clk    (clk),
      .rst_n  (rst_n),
      .hw_set (par_err_i),
      .sw_clr (wr_en_i & ~wr_data_i[BIT_PFLAG]),
      .q      (flag_q)
   );

   opctl_sticky_bit u_reload (
      .clk    (clk),
      .rst_n  (rst_n),
      .hw_set (reload_evt_i),
      .sw_clr (wr_en_i & ~wr_data_i[BIT_RELOAD]),
      .q      (reload_q)
   );

   opctl_once_field #(.N(ONCE_N)) u_once (
      .clk   (clk),
      .rst_n (rst_n),
      .wr_en (wr_en_i),
      .d     ({wr_data_i[BIT_ERRRDR], wr_data_i[BIT_LIMSRC]}),
      .q     (once_q)
   );

   // one slice per bit position; the kind of the bit picks the logic
   generate
      for (genvar i = 0; i < REG_W; i++) begin : g_bit
         if (kind_of(i) == KIND_PLAIN) begin : g_plain
            logic bit_q;
            if (clears_on_trip(i)) begin : g_trip
               always_ff @(posedge clk or negedge rst_n) begin
                  if (!rst_n)       bit_q <= 1'b0;
                  else if (trip)    bit_q <= 1'b0;
                  else if (wr_en_i) bit_q <= wr_data_i[i];
               end
            end else begin : g_norm
               always_ff @(posedge clk or negedge rst_n) begin
                  if (!rst_n)       bit_q <= 1'b0;
                  else if (wr_en_i) bit_q <= wr_data_i[i];
               end
            end
            assign reg_q[i] = bit_q;
         end else if (kind_of(i) == KIND_SPECIAL) begin : g_spec
            if (i == BIT_PFLAG) begin : g_f
               assign reg_q[i] = flag_q;
            end else if (i == BIT_RELOAD) begin : g_r
               assign reg_q[i] = reload_q;
            end else if (i == BIT_ERRRDR) begin : g_e
               assign reg_q[i] = once_q[1];
            end else begin : g_l
               assign reg_q[i] = once_q[0];
            end
         end else begin : g_rsvd
            assign reg_q[i] = 1'b0;
         end
      end
   endgenerate

   assign rd_data_o       = reg_q;
   assign par_flag_o      = reg_q[BIT_PFLAG];
   assign par_chk_en_o    = reg_q[BIT_PCHK];
   assign a20_mask_o      = reg_q[BIT_A20];
   assign snoop_en_o      = reg_q[BIT_SNOOP];
   assign flush_snoop_o   = reg_q[BIT_FSNOOP] & ~reg_q[BIT_SNOOP];
   assign pwr_int_en_o    = reg_q[BIT_PWRINT];
   assign rgn_nocache_o   = reg_q[BIT_RGNNC];
   assign cache_en_o      = reg_q[BIT_CEN];
   assign lock_nocache_o  = reg_q[BIT_LOCKNC];
   assign limit_src_o     = reg_q[BIT_LIMSRC];
   assign reload_seen_o   = reg_q[BIT_RELOAD];
   assign out_wait_rdy_o  = reg_q[BIT_OWAIT];
   assign halt_clk_stop_o = halt_i & reg_q[BIT_LPHALT];
   assign err_redirect_o  = reg_q[BIT_ERRRDR];
   assign fp_cacheable_o  = reg_q[BIT_FPC];
   assign par_odd_o       = reg_q[BIT_PODD];
   assign force_ext_rd_o  = reg_q[BIT_FEXT];
   assign pla_pwrdn_o     = halt_clk_stop_o & reg_q[BIT_PLA];

   // R3
   reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((rd_data_o >> USED_BITS) == '0) && !rd_data_o[BIT_HOLE]);

   // R5 R9
   trip_effect_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (par_err_i && rd_data_o[BIT_PCHK]) |=>
         (flush_req_o && (nmi_req_o || !NMI_ON_TRIP) && !rd_data_o[BIT_PCHK]
          && !rd_data_o[BIT_CEN] && rd_data_o[BIT_PFLAG]));

   // R6
   quiet_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (par_err_i && !rd_data_o[BIT_PCHK]) |=>
         (rd_data_o[BIT_PFLAG] && !flush_req_o && !nmi_req_o));
endmodule

// File: tb/proc_opctl_reg_tb_top.sv
module proc_opctl_reg_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int NV = 13;

   // vector table: write strobe, data, parity error, reload event, expected value, expected pulses
   localparam logic        V_WR [NV] = '{1,1,0,1,1,1,0,0,1,1,0,1,1};
   localparam logic [63:0] V_WD [NV] = '{64'hFFFF_FFFF_FFFF_FFFE, 64'h0, 64'h0, 64'h0, 64'h0,
                                         64'h82, 64'h0, 64'h0, 64'h83, 64'h208E, 64'h0,
                                         64'h0, 64'h10};
   localparam logic        V_PE [NV] = '{0,0,0,0,0,0,1,0,0,1,1,0,0};
   localparam logic        V_RL [NV] = '{0,0,1,1,0,0,0,0,0,0,0,0,0};
   localparam logic [63:0] V_EX [NV] = '{64'h7F6FE, 64'h4400, 64'h4C00, 64'h4C00, 64'h4400,
                                         64'h4482, 64'h4401, 64'h4401, 64'h4483, 64'h640D,
                                         64'h640D, 64'h4400, 64'h4410};
   localparam logic        V_PU [NV] = '{0,0,0,0,0,0,1,0,0,1,0,0,0};
   string vtag [NV] = '{"R2 R3 R4 R7 R8", "R4", "R8", "R8", "R8", "R2", "R5", "R5",
                        "R7", "R9", "R6", "R7", "R2"};

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic wr_en = 1'b0;
   logic [63:0] wr_data = '0;
   logic par_err = 1'b0;
   logic reload_evt = 1'b0;
   logic halt = 1'b0;
   logic [63:0] rd_data;
   logic flush_req, nmi_req, par_flag, par_chk_en, a20_mask, snoop_en, flush_snoop;
   logic pwr_int_en, rgn_nocache, cache_en, lock_nocache, limit_src, reload_seen;
   logic out_wait_rdy, halt_clk_stop, err_redirect, fp_cacheable, par_odd;
   logic force_ext_rd, pla_pwrdn;

   int total = 0;
   int bad = 0;
   bit finished = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   proc_opctl_reg dut_i (
      .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en), .wr_data_i(wr_data),
      .par_err_i(par_err), .reload_evt_i(reload_evt), .halt_i(halt),
      .rd_data_o(rd_data), .flush_req_o(flush_req), .nmi_req_o(nmi_req),
      .par_flag_o(par_flag), .par_chk_en_o(par_chk_en), .a20_mask_o(a20_mask),
      .snoop_en_o(snoop_en), .flush_snoop_o(flush_snoop), .pwr_int_en_o(pwr_int_en),
      .rgn_nocache_o(rgn_nocache), .cache_en_o(cache_en), .lock_nocache_o(lock_nocache),
      .limit_src_o(limit_src), .reload_seen_o(reload_seen), .out_wait_rdy_o(out_wait_rdy),
      .halt_clk_stop_o(halt_clk_stop), .err_redirect_o(err_redirect),
      .fp_cacheable_o(fp_cacheable), .par_odd_o(par_odd), .force_ext_rd_o(force_ext_rd),
      .pla_pwrdn_o(pla_pwrdn)
   );

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // drive one cycle of inputs at a falling edge, then idle them at the next falling edge
   task automatic cycle(input logic w, input logic [63:0] d, input logic pe, input logic rl);
      wr_en = w; wr_data = d; par_err = pe; reload_evt = rl;
      @(negedge clk);
      wr_en = 1'b0; wr_data = '0; par_err = 1'b0; reload_evt = 1'b0;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      // R1 reset state
      chk("R1 rd", rd_data, 64'h0);
      chk("R1 pulses", {62'h0, flush_req, nmi_req}, 64'h0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 after release", rd_data, 64'h0);

      for (int i = 0; i < NV; i++) begin
         cycle(V_WR[i], V_WD[i], V_PE[i], V_RL[i]);
         chk(vtag[i], rd_data, V_EX[i]);
         chk({vtag[i], " pulses"}, {62'h0, flush_req, nmi_req}, {62'h0, V_PU[i], V_PU[i]});
      end

      // R5 cache enable and parity bits came back cleared after the same-cycle case
      chk("R9 cache_en", {63'h0, cache_en}, 64'h0);
      chk("R2 limit_src", {63'h0, limit_src}, 64'h1);

      // R10 flush snooping gated by snoop input
      chk("R10 active", {63'h0, flush_snoop}, 64'h1);
      cycle(1'b1, 64'h18, 1'b0, 1'b0);
      chk("R10 gated", {62'h0, flush_snoop, snoop_en}, 64'h1);

      // R11 halt decoding
      cycle(1'b1, 64'h42000, 1'b0, 1'b0);
      halt = 1'b1;
      #1;
      chk("R11 stop+pla", {62'h0, halt_clk_stop, pla_pwrdn}, 64'h3);
      halt = 1'b0;
      #1;
      chk("R11 no halt", {62'h0, halt_clk_stop, pla_pwrdn}, 64'h0);
      @(negedge clk);
      cycle(1'b1, 64'h2000, 1'b0, 1'b0);
      halt = 1'b1;
      #1;
      chk("R11 stop only", {62'h0, halt_clk_stop, pla_pwrdn}, 64'h2);
      halt = 1'b0;
      @(negedge clk);

      // R1 reset mid-run, then R4 lock armed by a first write of zero
      rst_n = 1'b0;
      @(negedge clk);
      chk("R1 re-reset", rd_data, 64'h0);
      rst_n = 1'b1;
      @(negedge clk);
      cycle(1'b1, 64'h0, 1'b0, 1'b0);
      cycle(1'b1, 64'h4400, 1'b0, 1'b0);
      chk("R4 locked zero", rd_data, 64'h0);
      chk("R4 pins", {62'h0, err_redirect, limit_src}, 64'h0);

      // R6 parity error with checking off
      cycle(1'b1, 64'h80, 1'b0, 1'b0);
      cycle(1'b0, 64'h0, 1'b1, 1'b0);
      chk("R6 flag only", rd_data, 64'h81);
      chk("R6 no pulse", {62'h0, flush_req, nmi_req}, 64'h0);

      finished = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         total++;
         bad++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule